// File: doc/BRIEF.md
# AHB-Lite Wait-State Transfer-Type Conditioner

This block is placed on the address-phase control path between an AHB-Lite master and the slaves behind it. Some masters withdraw a pending NONSEQ or SEQ transfer by switching the transfer type to IDLE while the slave is still stretching the current data phase. Slaves expect the transfer type to hold steady during wait states, apart from a few permitted changes. The conditioner hides that withdrawal from the slaves. It presents IDLE as the slave-side transfer type on every cycle in which the bus ready signal is low, and it passes the master's value straight through when ready is high.

The other address-phase controls (address, write, size, burst and protection) pass through unchanged. Slaves latch the address phase only on a cycle with ready high, so they always capture the live values. A monitor watches the master-side transfer type across consecutive wait cycles. When the type changes in a way the protocol's wait-state rules forbid, it raises a single-cycle violation flag on the cycle after the change. A cancellation to IDLE counts as such a change.

Top module: `ahbl_wait_conditioner`

## Requirements
- R1: The transfer type uses the encoding IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. While `bus_ready` is low, `s_ttype` is IDLE in the same cycle, whatever `m_ttype` holds.
- R2: While `bus_ready` is high and reset is released, `s_ttype` equals `m_ttype` in the same cycle.
- R3: `s_addr`, `s_write`, `s_size`, `s_burst` and `s_prot` always equal their master-side inputs in the same cycle, whether ready is high or low.
- R4: While `rst_n` is low, `s_ttype` is IDLE and `ttype_viol` is low. After release, the monitor holds no earlier wait history, so the first wait cycle after reset can never raise the flag.
- R5: When `m_ttype` is NONSEQ or SEQ in one wait cycle and IDLE in the directly following wait cycle, `ttype_viol` is high for the cycle after the second one.
- R6: A change from IDLE to NONSEQ between two consecutive wait cycles does not raise `ttype_viol`. The same holds when the type stays unchanged.
- R7: The burst encoding 3'b001 is the undefined-length incrementing burst. Every other `m_burst` value counts as fixed-length. In a fixed-length burst, BUSY to SEQ across consecutive wait cycles is permitted. BUSY to any other different type raises `ttype_viol` on the following cycle.
- R8: When `m_burst` is 3'b001 in the second wait cycle, BUSY may change to any type without raising `ttype_viol`.
- R9: `ttype_viol` depends only on two consecutive wait cycles. A cycle with `bus_ready` high is always followed by `ttype_viol` low, so no change across a ready-high cycle is ever flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ready | input | 1 | Shared bus ready; low means the slave is inserting a wait state |
| m_ttype | input | 2 | Master-side transfer type |
| m_burst | input | 3 | Master-side burst type |
| m_addr | input | ADDR_W (32) | Master-side address |
| m_write | input | 1 | Master-side write/read direction |
| m_size | input | 3 | Master-side transfer size |
| m_prot | input | PROT_W (4) | Master-side protection attributes |
| s_ttype | output | 2 | Slave-side transfer type, forced to IDLE during waits |
| s_burst | output | 3 | Slave-side burst type |
| s_addr | output | ADDR_W (32) | Slave-side address |
| s_write | output | 1 | Slave-side write/read direction |
| s_size | output | 3 | Slave-side transfer size |
| s_prot | output | PROT_W (4) | Slave-side protection attributes |
| ttype_viol | output | 1 | One-cycle pulse after an illegal type change between two wait cycles |

## Verification
A master cancellation exercises masking and monitoring together. While ready is low, the NONSEQ-to-IDLE change must stay hidden on `s_ttype` (still IDLE), and the monitor must flag it one cycle later. That flag often lands on the cycle where ready returns and `s_ttype` begins to follow the master again. The bench provokes this by ending each cancellation sequence with a ready-high cycle. In that cycle it judges the pass-through value and the pending flag against its own model. It also chains two illegal changes back to back, to confirm that the flag pulses on consecutive cycles rather than merging or being lost.

// File: rtl/ahbl_cond_pkg.sv
// Package: shared transfer-type and burst encodings for the conditioner.
// Assumes the standard AHB-Lite two-bit transfer-type coding.
package ahbl_cond_pkg;

    typedef enum logic [1:0] {
        TT_IDLE   = 2'b00,
        TT_BUSY   = 2'b01,
        TT_NONSEQ = 2'b10,
        TT_SEQ    = 2'b11
    } ttype_e;

    localparam int TTYPE_W = 2;
    localparam int BURST_W = 3;
    localparam int SIZE_W  = 3;
    localparam logic [BURST_W-1:0] BURST_OPEN_INCR = 3'b001;

    // Decide whether a type change between two wait cycles is permitted.
    function automatic logic change_allowed(
        input ttype_e prev,
        input ttype_e cur,
        input logic   open_len
    );
        logic ok;
        ok = 1'b0;
        if (prev == cur)
            ok = 1'b1;
        else if (prev == TT_IDLE && cur == TT_NONSEQ)
            ok = 1'b1;
        else if (prev == TT_BUSY && (open_len || cur == TT_SEQ))
            ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/ahbl_ttype_mask.sv
// Module: forces the slave-side transfer type to IDLE during wait states
// and while reset is asserted; otherwise passes the master value through.
// Assumes slaves latch the address phase only when ready is high.
module ahbl_ttype_mask
    import ahbl_cond_pkg::*;
(
    input  logic               rst_n,
    input  logic               bus_ready,
    input  logic [TTYPE_W-1:0] m_ttype,
    output logic [TTYPE_W-1:0] s_ttype
);

    // Select either the live master type or IDLE.
    always_comb begin
        if (rst_n && bus_ready)
            s_ttype = m_ttype;
        else
            s_ttype = TT_IDLE;
    end

endmodule

// File: rtl/ahbl_ctrl_pass.sv
// Module: forwards the non-type address-phase controls unchanged.
// Assumes slaves sample these only on a ready-high edge, so no holding is needed.
module ahbl_ctrl_pass
    import ahbl_cond_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PROT_W = 4
) (
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic               m_write,
    input  logic [SIZE_W-1:0]  m_size,
    input  logic [BURST_W-1:0] m_burst,
    input  logic [PROT_W-1:0]  m_prot,
    output logic [ADDR_W-1:0]  s_addr,
    output logic               s_write,
    output logic [SIZE_W-1:0]  s_size,
    output logic [BURST_W-1:0] s_burst,
    output logic [PROT_W-1:0]  s_prot
);

    // Straight wiring of every control field.
    always_comb begin
        s_addr  = m_addr;
        s_write = m_write;
        s_size  = m_size;
        s_burst = m_burst;
        s_prot  = m_prot;
    end

endmodule

// File: rtl/ahbl_ttype_monitor.sv
// Module: remembers the master transfer type on each wait cycle and, when
// the next cycle is also a wait, flags an illegal change one cycle later.
// Assumes the burst type of the later wait cycle decides fixed vs open length.
module ahbl_ttype_monitor
    import ahbl_cond_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ready,
    input  logic [TTYPE_W-1:0] m_ttype,
    input  logic [BURST_W-1:0] m_burst,
    output logic               ttype_viol
);

    logic   wait_q;
    ttype_e prev_q;
    logic   viol_q;
    logic   open_len;
    logic   illegal;

    // Classify the live cycle against the remembered wait-cycle type.
    always_comb begin
        open_len = (m_burst == BURST_OPEN_INCR);
        illegal  = wait_q && !bus_ready &&
                   !change_allowed(prev_q, ttype_e'(m_ttype), open_len);
    end

    // Track wait history and register the violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            prev_q <= TT_IDLE;
            viol_q <= 1'b0;
        end else begin
            viol_q <= illegal;
            wait_q <= !bus_ready;
            if (!bus_ready)
                prev_q <= ttype_e'(m_ttype);
        end
    end

    assign ttype_viol = viol_q;

endmodule

// File: rtl/ahbl_wait_conditioner.sv
// Top: conditions address-phase controls from a master that may cancel a
// pending transfer during wait states, and reports illegal type changes.
// Assumes a single master and a shared ready; data phase is not touched.
module ahbl_wait_conditioner
    import ahbl_cond_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PROT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ready,
    input  logic [1:0]         m_ttype,
    input  logic [2:0]         m_burst,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic               m_write,
    input  logic [2:0]         m_size,
    input  logic [PROT_W-1:0]  m_prot,
    output logic [1:0]         s_ttype,
    output logic [2:0]         s_burst,
    output logic [ADDR_W-1:0]  s_addr,
    output logic               s_write,
    output logic [2:0]         s_size,
    output logic [PROT_W-1:0]  s_prot,
    output logic               ttype_viol
);

    // Transfer-type masking toward the slaves.
    ahbl_ttype_mask u_mask (
        .rst_n     (rst_n),
        .bus_ready (bus_ready),
        .m_ttype   (m_ttype),
        .s_ttype   (s_ttype)
    );

    // Unchanged forwarding of the remaining controls.
    ahbl_ctrl_pass #(
        .ADDR_W (ADDR_W),
        .PROT_W (PROT_W)
    ) u_pass (
        .m_addr  (m_addr),
        .m_write (m_write),
        .m_size  (m_size),
        .m_burst (m_burst),
        .m_prot  (m_prot),
        .s_addr  (s_addr),
        .s_write (s_write),
        .s_size  (s_size),
        .s_burst (s_burst),
        .s_prot  (s_prot)
    );

    // Master-side wait-state rule monitor.
    ahbl_ttype_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ready  (bus_ready),
        .m_ttype    (m_ttype),
        .m_burst    (m_burst),
        .ttype_viol (ttype_viol)
    );

endmodule

// File: rtl/ahbl_wait_conditioner_chk.sv
// Checker: temporal properties of the conditioner, bound to the top module.
module ahbl_wait_conditioner_chk #(
    parameter int ADDR_W = 32,
    parameter int PROT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ready,
    input logic [1:0]        m_ttype,
    input logic [2:0]        m_burst,
    input logic [ADDR_W-1:0] m_addr,
    input logic [1:0]        s_ttype,
    input logic [ADDR_W-1:0] s_addr,
    input logic              ttype_viol
);

    // R1
    mask_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> s_ttype == 2'b00);

    // R2
    pass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> s_ttype == m_ttype);

    // R3
    addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_addr == m_addr);

    // R4
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (s_ttype == 2'b00);
        end
    end

    // R5
    cancel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && m_ttype[1]) ##1 (!bus_ready && m_ttype == 2'b00) |=> ttype_viol);

    // R6
    idle_nonseq_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && m_ttype == 2'b00) ##1 (!bus_ready && m_ttype == 2'b10) |=> !ttype_viol);

    // R8
    open_busy_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && m_ttype == 2'b01) ##1 (!bus_ready && m_burst == 3'b001) |=> !ttype_viol);

    // R9
    ready_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !ttype_viol);

endmodule

bind ahbl_wait_conditioner ahbl_wait_conditioner_chk #(
    .ADDR_W (ADDR_W),
    .PROT_W (PROT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ready  (bus_ready),
    .m_ttype    (m_ttype),
    .m_burst    (m_burst),
    .m_addr     (m_addr),
    .s_ttype    (s_ttype),
    .s_addr     (s_addr),
    .ttype_viol (ttype_viol)
);

// File: tb/test_ahbl_wait_conditioner.sv
// Scoreboard bench: the driver applies one cycle of stimulus per negedge and
// queues the expected outputs; the monitor compares them a quarter period later.
module test_ahbl_wait_conditioner;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int PROT_W = 4;
    localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;
    localparam logic [2:0] SINGLE = 3'b000, INCR = 3'b001, INCR4 = 3'b011;
    localparam int CTRL_W = ADDR_W + 1 + 3 + 3 + PROT_W;

    typedef struct {
        logic [1:0]        ttype;
        logic              viol;
        logic [CTRL_W-1:0] ctrl;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_ready = 1'b1;
    logic [1:0]        m_ttype = IDLE;
    logic [2:0]        m_burst = SINGLE;
    logic [ADDR_W-1:0] m_addr = '0;
    logic              m_write = 1'b0;
    logic [2:0]        m_size = 3'd2;
    logic [PROT_W-1:0] m_prot = '0;
    logic [1:0]        s_ttype;
    logic [2:0]        s_burst;
    logic [ADDR_W-1:0] s_addr;
    logic              s_write;
    logic [2:0]        s_size;
    logic [PROT_W-1:0] s_prot;
    logic              ttype_viol;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    logic done = 1'b0;

    // Model state kept from the requirements alone.
    logic       md_wait = 1'b0;
    logic [1:0] md_prev = IDLE;
    logic       md_pend = 1'b0;
    int         step_no = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahbl_wait_conditioner #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) i_ahbl_wait_conditioner (
        .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready),
        .m_ttype(m_ttype), .m_burst(m_burst), .m_addr(m_addr),
        .m_write(m_write), .m_size(m_size), .m_prot(m_prot),
        .s_ttype(s_ttype), .s_burst(s_burst), .s_addr(s_addr),
        .s_write(s_write), .s_size(s_size), .s_prot(s_prot),
        .ttype_viol(ttype_viol)
    );

    // Permitted-change rule from R6, R7 and R8.
    function automatic logic permitted(input logic [1:0] a, input logic [1:0] b,
                                       input logic [2:0] burst);
        if (a == b) return 1'b1;
        if (a == IDLE && b == NSEQ) return 1'b1;
        if (a == BUSY && burst == INCR) return 1'b1;
        if (a == BUSY && b == SEQ) return 1'b1;
        return 1'b0;
    endfunction

    // Drive one cycle and queue its expected outputs.
    task automatic step(input logic rv, input logic rdy, input logic [1:0] tt,
                        input logic [2:0] bu, input string req);
        exp_t e;
        @(negedge clk);
        step_no++;
        rst_n     = rv;
        bus_ready = rdy;
        m_ttype   = tt;
        m_burst   = bu;
        m_addr    = 32'h1000_0000 + 32'(step_no * 4);
        m_write   = step_no[0];
        m_size    = 3'(step_no % 3);
        m_prot    = 4'(step_no);
        e.ttype = (rv && rdy) ? tt : IDLE;
        e.viol  = md_pend;
        e.ctrl  = {m_addr, m_write, m_size, m_burst, m_prot};
        e.req   = req;
        sb_q.push_back(e);
        if (!rv) begin
            md_pend = 1'b0;
            md_wait = 1'b0;
            md_prev = IDLE;
        end else begin
            md_pend = md_wait && !rdy && !permitted(md_prev, tt, bu);
            md_wait = !rdy;
            if (!rdy) md_prev = tt;
        end
    endtask

    // Monitor: pop and compare each queued cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (s_ttype !== e.ttype) begin
                    errors++;
                    $display("FAIL %s s_ttype actual %b expected %b", e.req, s_ttype, e.ttype);
                end
                checks++;
                if (ttype_viol !== e.viol) begin
                    errors++;
                    $display("FAIL %s ttype_viol actual %b expected %b", e.req, ttype_viol, e.viol);
                end
                checks++;
                if ({s_addr, s_write, s_size, s_burst, s_prot} !== e.ctrl) begin
                    errors++;
                    $display("FAIL R3 controls actual %h expected %h",
                             {s_addr, s_write, s_size, s_burst, s_prot}, e.ctrl);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus sequences.
    initial begin
        // R4: reset masks type, flag low, history cleared
        step(1'b0, 1'b1, NSEQ, SINGLE, "R4");
        step(1'b0, 1'b0, NSEQ, SINGLE, "R4");
        step(1'b1, 1'b0, IDLE, SINGLE, "R4");
        step(1'b1, 1'b1, IDLE, SINGLE, "R4");
        // R2: pass-through with ready high
        step(1'b1, 1'b1, NSEQ, INCR, "R2");
        step(1'b1, 1'b1, SEQ, INCR, "R2");
        step(1'b1, 1'b1, BUSY, INCR, "R2");
        // R5: NONSEQ cancelled to IDLE, masked by R1
        step(1'b1, 1'b0, NSEQ, SINGLE, "R1");
        step(1'b1, 1'b0, IDLE, SINGLE, "R1");
        step(1'b1, 1'b1, IDLE, SINGLE, "R5");
        // R5: SEQ cancelled in a fixed burst
        step(1'b1, 1'b0, SEQ, INCR4, "R1");
        step(1'b1, 1'b0, IDLE, INCR4, "R5");
        step(1'b1, 1'b1, NSEQ, INCR4, "R5");
        // R6: IDLE to NONSEQ permitted, steady type permitted
        step(1'b1, 1'b0, IDLE, SINGLE, "R6");
        step(1'b1, 1'b0, NSEQ, SINGLE, "R6");
        step(1'b1, 1'b0, NSEQ, SINGLE, "R6");
        step(1'b1, 1'b1, NSEQ, SINGLE, "R6");
        // R7: BUSY to SEQ permitted in fixed burst
        step(1'b1, 1'b0, BUSY, INCR4, "R7");
        step(1'b1, 1'b0, SEQ, INCR4, "R7");
        step(1'b1, 1'b1, SEQ, INCR4, "R7");
        // R7: BUSY to NONSEQ flagged in fixed burst
        step(1'b1, 1'b0, BUSY, INCR4, "R7");
        step(1'b1, 1'b0, NSEQ, INCR4, "R7");
        step(1'b1, 1'b1, NSEQ, INCR4, "R7");
        // R8: BUSY to NONSEQ and BUSY to IDLE permitted in open burst
        step(1'b1, 1'b0, BUSY, INCR, "R8");
        step(1'b1, 1'b0, NSEQ, INCR, "R8");
        step(1'b1, 1'b1, NSEQ, INCR, "R8");
        step(1'b1, 1'b0, BUSY, INCR, "R8");
        step(1'b1, 1'b0, IDLE, INCR, "R8");
        step(1'b1, 1'b1, IDLE, INCR, "R8");
        // R9: change across a ready-high cycle not flagged
        step(1'b1, 1'b0, NSEQ, SINGLE, "R9");
        step(1'b1, 1'b1, IDLE, SINGLE, "R9");
        step(1'b1, 1'b0, IDLE, SINGLE, "R9");
        step(1'b1, 1'b1, IDLE, SINGLE, "R9");
        // R5 and R7 back to back: SEQ->IDLE then IDLE->BUSY, two pulses
        step(1'b1, 1'b0, SEQ, INCR4, "R5");
        step(1'b1, 1'b0, IDLE, INCR4, "R5");
        step(1'b1, 1'b0, BUSY, INCR4, "R7");
        step(1'b1, 1'b1, BUSY, INCR4, "R7");
        step(1'b1, 1'b1, IDLE, SINGLE, "R9");
        // R4: reset mid-wait clears history
        step(1'b1, 1'b0, NSEQ, SINGLE, "R4");
        step(1'b0, 1'b0, NSEQ, SINGLE, "R4");
        step(1'b1, 1'b0, IDLE, SINGLE, "R4");
        step(1'b1, 1'b1, IDLE, SINGLE, "R4");
        @(negedge clk);
        @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule